// File: doc/BRIEF.md
# Nanosecond Time Counter with Drift Trim

This block keeps a 64-bit time of day in nanoseconds. While it runs, the count grows by the nominal clock period on every clock. Software can trim the long-term rate by giving a small correction, an add or a subtract of 0 to 7 ns. The correction is applied once at the end of each programmable interval. The trim gives a slow, even frequency adjustment without a fractional accumulator.

Software reaches the block through a small word-wide register port. Writes take effect on the clock edge that accepts them. Reads return data one clock after the read strobe. To set the time, software pauses the counter, writes the low and high halves, and resumes it. To read the time, software reads the low half first; that read captures the high half, so the two reads give one consistent value. The drift settings sit behind a separate hold control. Software holds the drift logic, writes the settings word, then releases the hold to start corrections.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the counter is running, the time is zero, the drift settings word reads 0, and the drift hold (address 6) reads 0.
- R2: Writing 2 to the control register (address 0) pauses the counter, and writing 4 resumes it. Any other value written there has no effect. A read of address 0 returns 1 in bit 0 while running and 0 while paused.
- R3: While the counter is paused, its value does not change.
- R4: While the counter is paused, a write to address 1 replaces time bits [31:0] and a write to address 2 replaces bits [63:32]. While it runs, writes to these two addresses are ignored.
- R5: While running with no correction due, the time advances by NS_PER_CLK per clock and wraps modulo 2^64, with the carry passing from the low half into the high half.
- R6: A read of address 3 returns time bits [31:0] and captures bits [63:32] at the same instant. A later read of address 4 returns that captured high half, whatever the time has done since.
- R7: Bit 0 of address 6 is the drift hold and reads back as written. While the hold is set, no correction is applied and the interval count stays at zero.
- R8: A write to address 5, the drift settings word, is accepted only while the drift hold is set; otherwise it is ignored. A read of address 5 returns the stored word.
- R9: The settings word holds the period P in bits [27:0], the amount A in bits [30:28], and the direction in bit 31 (1 adds, 0 subtracts). The interval I is 16·P + 8 ns.
- R10: After the hold is released, each running clock adds NS_PER_CLK to the interval count. On the clock where the count would reach I, the time moves by NS_PER_CLK ± A instead of NS_PER_CLK, and the interval count restarts from zero.
- R11: A settings word with amount 0 leaves the rate at its nominal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |

## Verification
The bench uses the default NS_PER_CLK of 8, so one clock equals the shortest interval, 8 ns at P = 0. This makes a correction on every clock testable, alongside intervals of three and five clocks. With P within a few counts of zero, each trim run ends in tens of cycles, and the expected time is 8·w ± A·floor(w / (2P+1)). Loading values near a 32-bit and a 64-bit boundary shows, within one or two clocks, the carry into the high half, the wrap, and the captured high half staying unchanged.

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int NS_PER_CLK = 8,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int TIME_W = 64;
  localparam int PER_W  = 28;
  localparam int ACC_W  = PER_W + 6;

  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LOAD_LO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LOAD_HI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TIME_LO = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TIME_HI = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TRIM    = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_HOLD    = ADDR_W'(6);

  logic [TIME_W-1:0] time_q;
  logic              run_q;
  logic              hold_q;
  logic [31:0]       trim_q;
  logic [ACC_W-1:0]  acc_q;
  logic [31:0]       hi_snap_q;
  logic [31:0]       rdata_q;

  logic [PER_W-1:0]  per;
  logic [2:0]        amt;
  logic              add_dir;
  assign per     = trim_q[PER_W-1:0];
  assign amt     = trim_q[30:28];
  assign add_dir = trim_q[31];

  logic [ACC_W-1:0] interval;
  logic [ACC_W-1:0] acc_next;
  logic             counting;
  logic             due;
  assign interval = {{(ACC_W-PER_W-4){1'b0}}, per, 4'b0000} + ACC_W'(8);
  assign acc_next = acc_q + ACC_W'(NS_PER_CLK);
  assign counting = run_q && !hold_q;
  assign due      = counting && (acc_next >= interval);

  logic [TIME_W-1:0] step;
  always_comb begin
    step = TIME_W'(NS_PER_CLK);
    if (due) step = add_dir ? step + TIME_W'(amt) : step - TIME_W'(amt);
  end

  logic wr_ctrl, wr_lo, wr_hi, wr_trim, wr_hold;
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_lo   = wr_en && (addr == A_LOAD_LO);
  assign wr_hi   = wr_en && (addr == A_LOAD_HI);
  assign wr_trim = wr_en && (addr == A_TRIM);
  assign wr_hold = wr_en && (addr == A_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q    <= '0;
      run_q     <= 1'b1;
      hold_q    <= 1'b0;
      trim_q    <= '0;
      acc_q     <= '0;
      hi_snap_q <= '0;
      rdata_q   <= '0;
    end else begin
      if (wr_ctrl && wdata == 32'd2)      run_q <= 1'b0;
      else if (wr_ctrl && wdata == 32'd4) run_q <= 1'b1;

      if (run_q) time_q <= time_q + step;
      else begin
        if (wr_lo) time_q[31:0]  <= wdata;
        if (wr_hi) time_q[63:32] <= wdata;
      end

      if (wr_hold) hold_q <= wdata[0];
      if (wr_trim && hold_q) trim_q <= wdata;

      if (hold_q)     acc_q <= '0;
      else if (run_q) acc_q <= due ? '0 : acc_next;

      if (rd_en) begin
        case (addr)
          A_CTRL:    rdata_q <= {31'b0, run_q};
          A_TIME_LO: begin
            rdata_q   <= time_q[31:0];
            hi_snap_q <= time_q[63:32];
          end
          A_TIME_HI: rdata_q <= hi_snap_q;
          A_TRIM:    rdata_q <= trim_q;
          A_HOLD:    rdata_q <= {31'b0, hold_q};
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata = rdata_q;

  a_r3_paused_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_lo && !wr_hi) |=> $stable(time_q));

  a_r5_nominal_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && amt == 3'd0) |=> time_q == $past(time_q) + TIME_W'(NS_PER_CLK));

  a_r7_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> acc_q == '0);

  a_r8_trim_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |=> $stable(trim_q));

  a_r10_acc_below_interval: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |-> acc_q < interval);
endmodule

// File: tb/tb_ptp_time_counter.sv
`timescale 1ns/1ps
module tb_ptp_time_counter;
  localparam int AW = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  ptp_time_counter #(.NS_PER_CLK(8), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_d = 1'b0;

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trim_run(input logic [31:0] cfg, input bit release_hold,
                          input int w, input int p, input int a, input bit add,
                          input string t);
    int k, n;
    logic [31:0] e;
    wr(0, 2); wr(1, 0); wr(2, 0);
    wr(6, 1); wr(5, cfg);
    if (release_hold) wr(6, 0);
    wr(0, 4);
    idle(w);
    k = 2 * p + 1;
    n = (release_hold && a != 0) ? w / k : 0;
    e = 32'(8 * w);
    if (add) e = e + 32'(a * n); else e = e - 32'(a * n);
    rd(3, e, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    rd(3, 32'h0, "R1 time lo after reset");
    rd(4, 32'h0, "R1 time hi after reset");
    rd(0, 32'h1, "R1 running after reset");
    rd(5, 32'h0, "R1 trim word after reset");
    rd(6, 32'h0, "R1 hold after reset");

    wr(0, 2);
    rd(0, 32'h0, "R2 paused status");
    wr(0, 6);
    rd(0, 32'h0, "R2 other value ignored");
    wr(1, 32'h0000_1234); wr(2, 32'h0000_ABCD);
    idle(10);
    rd(3, 32'h0000_1234, "R3 R4 paused lo");
    rd(4, 32'h0000_ABCD, "R3 R4 paused hi");

    wr(1, 32'h100); wr(2, 0);
    wr(0, 4);
    wr(1, 32'hDEAD);
    rd(3, 32'h108, "R4 load lo ignored while running");
    rd(4, 32'h0, "R4 hi unchanged");
    rd(0, 32'h1, "R2 resumed status");
    wr(0, 2); wr(1, 32'h100); wr(2, 0); wr(0, 4);
    wr(2, 32'h55);
    rd(3, 32'h108, "R5 one step");
    rd(4, 32'h0, "R4 load hi ignored while running");

    wr(0, 2); wr(1, 32'hFFFF_FFF8); wr(2, 32'hFFFF_FFFF); wr(0, 4);
    idle(1);
    rd(3, 32'h0, "R5 wrap lo");
    rd(4, 32'h0, "R5 wrap hi");

    wr(0, 2); wr(1, 32'hFFFF_FFF0); wr(2, 0); wr(0, 4);
    idle(1);
    rd(3, 32'hFFFF_FFF8, "R6 lo before carry");
    idle(3);
    rd(4, 32'h0, "R6 captured hi stays");
    rd(3, 32'h20, "R5 carry lo");
    rd(4, 32'h1, "R5 carry into hi");

    rd(6, 32'h0, "R7 hold clear");
    wr(5, 32'h1234_5678);
    rd(5, 32'h0, "R8 trim ignored without hold");
    wr(6, 1);
    rd(6, 32'h1, "R7 hold readback");
    wr(5, 32'hB000_0000);
    rd(5, 32'hB000_0000, "R8 trim accepted under hold");

    trim_run(32'hF000_0000, 1'b0, 12, 0, 7, 1'b1, "R7 no trim while held");
    trim_run(32'hB000_0000, 1'b1, 10, 0, 3, 1'b1, "R10 add every clock");
    trim_run(32'hF000_0001, 1'b1, 10, 1, 7, 1'b1, "R9 R10 add period 1");
    trim_run(32'h3000_0002, 1'b1, 23, 2, 3, 1'b0, "R9 R10 subtract period 2");
    trim_run(32'h8000_0000, 1'b1, 9, 0, 0, 1'b1, "R11 amount zero");
    trim_run(32'h0FFF_FFFF, 1'b1, 20, 0, 0, 1'b1, "R11 disabled word");

    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule